// File: doc/BRIEF.md
# Programmable-Priority Bus Arbiter with Power Modes

This block decides which of eight masters owns a shared system bus: a CPU, a DMA engine, three USB host ports, an Ethernet MAC, a display raster engine and a hardware cursor engine. A ninth grant line belongs to an internal dummy master. The dummy master only ever issues IDLE transfers and is used to hold the bus when no real master may own it. The winner is chosen by fixed priority. A 2-bit select picks one of four priority orderings, and the select can change while the system runs.

Two power modes change the outcome. In Halt the CPU is dropped from the contest, while every other master still competes. In Standby every real master is shut out and the dummy master takes the bus. An interrupt guard is also available: while an IRQ or FIQ is pending, any bulk master whose guard enable is set is ignored. The bulk masters are the DMA engine, the USB hosts and the MAC. The grant register moves only on a clock edge where `ready` is high, which marks a transfer boundary. Configuration comes in on plain inputs from a register file outside the block.

Top module: `bus_prio_arbiter`

## Requirements
- R1: After reset the grant vector is 9'h001, which is the CPU, and `owner` is 0.
- R2: `grant` is always one-hot across its nine bits. Bit 0 is the CPU, bit 1 DMA, bits 2..4 USB0..USB2, bit 5 MAC, bit 6 raster, bit 7 cursor and bit 8 dummy. `owner` holds the index of the set bit.
- R3: `grant` changes only on a rising edge where `ready` is 1, and the new value appears right after that edge. With `ready` at 0, `grant` holds.
- R4: Within a scheme the eligible requester with the highest priority wins. The orderings, highest first, are as follows. Scheme 0: cursor, MAC, USB, DMA, CPU, raster. Scheme 1: raster, cursor, MAC, USB, DMA, CPU. Scheme 2: DMA, MAC, USB, cursor, raster, CPU. Scheme 3: raster, DMA, MAC, USB, cursor, CPU.
- R5: The three USB hosts share one priority slot. Among the USB hosts that request, the lowest-numbered one wins.
- R6: If no eligible request is present outside the power modes, the grant parks on the CPU.
- R7: While `irq` or `fiq` is 1, requests are masked for each master class whose guard bit is set. The guard bits are `degrant_en[0]` for DMA, `[1]` for USB and `[2]` for MAC. With a guard bit at 0, or with no interrupt pending, that class is not masked.
- R8: While `halt` is 1 the CPU cannot win. If no other eligible request is present, the grant parks on the dummy master. Halt is applied together with interrupt masking.
- R9: While `standby` is 1 the dummy master is granted regardless of requests, `halt` and the scheme.
- R10: A change of `prio_sel` has no effect while `ready` is 0. It takes effect at the next edge where `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready | input | 1 | Transfer boundary; arbitration point |
| req | input | 8 | Requests, bit order as in R2 |
| prio_sel | input | 2 | Priority scheme select |
| degrant_en | input | 3 | Interrupt guard enables: DMA, USB, MAC |
| irq | input | 1 | IRQ pending |
| fiq | input | 1 | FIQ pending |
| halt | input | 1 | Halt mode request |
| standby | input | 1 | Standby mode request |
| grant | output | 9 | One-hot grant, bit 8 is dummy master |
| owner | output | 4 | Index of current bus owner |

## Verification
Every result of this block is due exactly one clock edge after it is sampled. The inputs present at an edge with `ready` high decide `grant` and `owner` right after that edge, and neither output changes on edges where `ready` is low. The bench drives inputs on the falling edge and checks on the next falling edge, so each check comes half a period after the single edge that should have produced the result. The hold tests keep `ready` low for several edges with altered requests and a new scheme select, and then confirm that the old grant is still present.

// File: rtl/bus_prio_arbiter_pkg.sv
package bus_prio_arbiter_pkg;
  localparam int N_USB   = 3;
  localparam int N_MST   = 5 + N_USB;
  localparam int N_GNT   = N_MST + 1;
  localparam int N_CLS   = 6;
  localparam int IDX_CPU = 0;
  localparam int IDX_DMA = 1;
  localparam int IDX_USB = 2;
  localparam int IDX_MAC = IDX_USB + N_USB;
  localparam int IDX_RAS = IDX_MAC + 1;
  localparam int IDX_CUR = IDX_RAS + 1;
  localparam int IDX_DUM = N_MST;
  localparam int OWN_W   = $clog2(N_GNT);

  typedef enum logic [2:0] {
    CL_CPU = 3'd0, CL_DMA = 3'd1, CL_USB = 3'd2,
    CL_MAC = 3'd3, CL_RAS = 3'd4, CL_CUR = 3'd5
  } cls_e;

  // Class held by a priority slot (slot 0 highest) in a given scheme.
  function automatic cls_e slot_class(input logic [1:0] sch, input int slot);
    logic [3*N_CLS-1:0] ord;
    case (sch)
      2'd0:    ord = {3'd4, 3'd0, 3'd1, 3'd2, 3'd3, 3'd5};
      2'd1:    ord = {3'd0, 3'd1, 3'd2, 3'd3, 3'd5, 3'd4};
      2'd2:    ord = {3'd0, 3'd4, 3'd5, 3'd2, 3'd3, 3'd1};
      default: ord = {3'd0, 3'd5, 3'd2, 3'd3, 3'd1, 3'd4};
    endcase
    return cls_e'(ord[slot*3 +: 3]);
  endfunction

  // One-hot grant for a winning class; USB picks its lowest requester.
  function automatic logic [N_GNT-1:0] class_grant(input cls_e c,
                                                   input logic [N_MST-1:0] e);
    logic [N_GNT-1:0] g;
    g = '0;
    case (c)
      CL_CPU: g[IDX_CPU] = 1'b1;
      CL_DMA: g[IDX_DMA] = 1'b1;
      CL_MAC: g[IDX_MAC] = 1'b1;
      CL_RAS: g[IDX_RAS] = 1'b1;
      CL_CUR: g[IDX_CUR] = 1'b1;
      default: begin
        for (int u = N_USB - 1; u >= 0; u--)
          if (e[IDX_USB + u]) begin
            g = '0;
            g[IDX_USB + u] = 1'b1;
          end
      end
    endcase
    return g;
  endfunction
endpackage

// File: rtl/arb_eligibility.sv
module arb_eligibility
  import bus_prio_arbiter_pkg::*;
(
  input  logic [N_MST-1:0] req,
  input  logic             halt,
  input  logic             irq,
  input  logic             fiq,
  input  logic [2:0]       degrant_en,
  output logic [N_MST-1:0] elig,
  output logic             int_pending
);
  assign int_pending = irq | fiq;

  always_comb begin
    elig = req;
    if (halt) elig[IDX_CPU] = 1'b0;
    if (int_pending && degrant_en[0]) elig[IDX_DMA] = 1'b0;
    if (int_pending && degrant_en[1]) elig[IDX_USB +: N_USB] = '0;
    if (int_pending && degrant_en[2]) elig[IDX_MAC] = 1'b0;
  end

  always_comb begin
    assert_halt_mask_R8: assert (!(halt && elig[IDX_CPU]));
  end
endmodule

// File: rtl/arb_select.sv
module arb_select
  import bus_prio_arbiter_pkg::*;
(
  input  logic [N_MST-1:0] elig,
  input  logic [1:0]       sch,
  input  logic             halt,
  input  logic             standby,
  output logic [N_GNT-1:0] nxt,
  output logic             any_elig
);
  logic [N_CLS-1:0] cls_req;
  logic             win_vld;
  cls_e             win_cls;

  assign cls_req[CL_CPU] = elig[IDX_CPU];
  assign cls_req[CL_DMA] = elig[IDX_DMA];
  assign cls_req[CL_USB] = |elig[IDX_USB +: N_USB];
  assign cls_req[CL_MAC] = elig[IDX_MAC];
  assign cls_req[CL_RAS] = elig[IDX_RAS];
  assign cls_req[CL_CUR] = elig[IDX_CUR];
  assign any_elig = |cls_req;

  always_comb begin
    win_vld = 1'b0;
    win_cls = CL_CPU;
    for (int s = N_CLS - 1; s >= 0; s--)
      if (cls_req[slot_class(sch, s)]) begin
        win_vld = 1'b1;
        win_cls = slot_class(sch, s);
      end
  end

  always_comb begin
    nxt = '0;
    if (standby)      nxt[IDX_DUM] = 1'b1;
    else if (win_vld) nxt = class_grant(win_cls, elig);
    else if (halt)    nxt[IDX_DUM] = 1'b1;
    else              nxt[IDX_CPU] = 1'b1;
  end

  always_comb begin
    assert_pick_onehot_R2: assert ($countones(nxt) == 1);
  end
endmodule

// File: rtl/bus_prio_arbiter.sv
module bus_prio_arbiter
  import bus_prio_arbiter_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready,
  input  logic [7:0]       req,
  input  logic [1:0]       prio_sel,
  input  logic [2:0]       degrant_en,
  input  logic             irq,
  input  logic             fiq,
  input  logic             halt,
  input  logic             standby,
  output logic [8:0]       grant,
  output logic [3:0]       owner
);
  logic [N_MST-1:0] elig;
  logic             int_pending;
  logic [N_GNT-1:0] nxt;
  logic             any_elig;
  logic [N_GNT-1:0] grant_q;

  arb_eligibility u_elig (
    .req(req), .halt(halt), .irq(irq), .fiq(fiq),
    .degrant_en(degrant_en), .elig(elig), .int_pending(int_pending)
  );

  arb_select u_sel (
    .elig(elig), .sch(prio_sel), .halt(halt), .standby(standby),
    .nxt(nxt), .any_elig(any_elig)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     grant_q <= N_GNT'(1);
    else if (ready) grant_q <= nxt;
  end

  always_comb begin
    owner = '0;
    for (int i = 0; i < N_GNT; i++)
      if (grant_q[i]) owner = OWN_W'(i);
  end

  assign grant = grant_q;

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant_q) == 1);
  assert_owner_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_q[owner]);
  assert_hold_no_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(grant_q));
  assert_standby_dummy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready && standby |=> grant_q[IDX_DUM]);
  assert_halt_no_cpu_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready && halt |=> !grant_q[IDX_CPU]);
  assert_dma_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready && int_pending && degrant_en[0] |=> !grant_q[IDX_DMA]);
  assert_park_cpu_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !any_elig && !halt && !standby |=> grant_q[IDX_CPU]);
endmodule

// File: tb/bus_prio_arbiter_test.sv
module bus_prio_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ready = 1'b0;
  logic [7:0] req = '0;
  logic [1:0] prio_sel = '0;
  logic [2:0] degrant_en = '0;
  logic       irq = 1'b0, fiq = 1'b0, halt = 1'b0, standby = 1'b0;
  logic [8:0] grant;
  logic [3:0] owner;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bus_prio_arbiter uut (
    .clk(clk), .rst_n(rst_n), .ready(ready), .req(req), .prio_sel(prio_sel),
    .degrant_en(degrant_en), .irq(irq), .fiq(fiq), .halt(halt),
    .standby(standby), .grant(grant), .owner(owner)
  );

  // {req, sel, guard, irq, fiq, halt, standby, expected grant}
  localparam int NV = 23;
  localparam logic [25:0] VEC [NV] = '{
    {8'h00, 2'd0, 3'b000, 4'b0000, 9'h001}, // R6 park on CPU
    {8'hFF, 2'd0, 3'b000, 4'b0000, 9'h080}, // R4 s0 cursor
    {8'h7F, 2'd0, 3'b000, 4'b0000, 9'h020}, // R4 s0 MAC
    {8'h5F, 2'd0, 3'b000, 4'b0000, 9'h004}, // R5 USB0 first
    {8'h18, 2'd0, 3'b000, 4'b0000, 9'h008}, // R5 USB1 over USB2
    {8'h43, 2'd0, 3'b000, 4'b0000, 9'h002}, // R4 s0 DMA
    {8'h41, 2'd0, 3'b000, 4'b0000, 9'h001}, // R4 s0 CPU over raster
    {8'hFF, 2'd1, 3'b000, 4'b0000, 9'h040}, // R4 s1 raster
    {8'h03, 2'd1, 3'b000, 4'b0000, 9'h002}, // R4 s1 DMA over CPU
    {8'hFF, 2'd2, 3'b000, 4'b0000, 9'h002}, // R4 s2 DMA
    {8'hE1, 2'd2, 3'b000, 4'b0000, 9'h020}, // R4 s2 MAC
    {8'hC1, 2'd2, 3'b000, 4'b0000, 9'h080}, // R4 s2 cursor
    {8'hBF, 2'd3, 3'b000, 4'b0000, 9'h002}, // R4 s3 DMA
    {8'h81, 2'd3, 3'b000, 4'b0000, 9'h080}, // R4 s3 cursor
    {8'h27, 2'd0, 3'b111, 4'b1000, 9'h001}, // R7 all bulk masked
    {8'h27, 2'd0, 3'b001, 4'b1000, 9'h020}, // R7 only DMA masked
    {8'h26, 2'd0, 3'b111, 4'b0100, 9'h001}, // R7 fiq, park CPU
    {8'h27, 2'd0, 3'b111, 4'b0000, 9'h020}, // R7 no interrupt
    {8'h01, 2'd0, 3'b000, 4'b0010, 9'h100}, // R8 park dummy
    {8'h41, 2'd0, 3'b000, 4'b0010, 9'h040}, // R8 raster wins
    {8'h27, 2'd0, 3'b111, 4'b1010, 9'h100}, // R8 halt plus mask
    {8'hFF, 2'd0, 3'b000, 4'b0011, 9'h100}, // R9 over halt
    {8'h01, 2'd3, 3'b000, 4'b0001, 9'h100}  // R9 standby
  };

  function automatic logic [3:0] idx_of(input logic [8:0] g);
    logic [3:0] k = 4'd0;
    for (int i = 0; i < 9; i++) if (g[i]) k = 4'(i);
    return k;
  endfunction

  task automatic check(input string tag, input logic [8:0] exp);
    checks++;
    if (grant !== exp) begin
      errors++;
      $display("FAIL %s grant actual %h expected %h", tag, grant, exp);
    end
    checks++;
    if (owner !== idx_of(exp)) begin
      errors++;
      $display("FAIL %s owner actual %0d expected %0d", tag, owner, idx_of(exp));
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", 9'h001);

    for (int v = 0; v < NV; v++) begin
      {req, prio_sel, degrant_en, irq, fiq, halt, standby} = VEC[v][25:9];
      ready = 1'b1;
      @(negedge clk);
      check($sformatf("R2/R4-R9 vector %0d", v), VEC[v][8:0]);
    end

    // R3: with ready low, grant holds dummy although requests change
    {irq, fiq, halt, standby} = '0;
    degrant_en = '0;
    ready = 1'b0;
    req = 8'hFF;
    prio_sel = 2'd0;
    repeat (3) @(negedge clk);
    check("R3 hold", 9'h100);
    ready = 1'b1;
    @(negedge clk);
    check("R3 release", 9'h080);

    // R10: select change waits for ready
    ready = 1'b0;
    prio_sel = 2'd1;
    repeat (2) @(negedge clk);
    check("R10 sel held", 9'h080);
    ready = 1'b1;
    @(negedge clk);
    check("R10 sel applied", 9'h040);

    // R1: reset again from a non-CPU owner
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset", 9'h001);
    rst_n = 1'b1;
    ready = 1'b0;
    @(negedge clk);
    check("R1 after reset hold", 9'h001);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule